// File: doc/BRIEF.md
# Serial NOR Flash Command Frame Decoder

This block is the device-side front end of a serial NOR flash. While chip select is low it takes in the serial data line on each rising clock edge, most significant bit first. It groups the bits into bytes and reads the first byte of each frame as a command code. The command code sets how many address bytes, dummy bytes and data bytes follow. The block then sends decoded requests to a memory-array model that sits beside it, and it drives read data back out on the serial output line.

A write-enable latch guards every command that changes the array. A program or erase request goes to the array only when chip select rises exactly on a byte boundary, and only if the latch is set at that moment. An accepted request clears the latch.

A frame is aborted, with no effect, in four cases:
- chip select rises part-way through a byte;
- the command code is unknown;
- a command that has no data phase receives extra bytes;
- a request is made while the latch is clear.

Dual-line command codes and the status-register and security-area writes count as unknown.

The serial pins are assumed to be synchronous to `clk`, and each serial clock phase must last at least four `clk` periods. The array model must return read data on the `clk` cycle after `rd_req`.

Top module: `spi_flash_cmd_decoder`

## Requirements
- R1: A frame starts on the falling edge of `spi_csn`. Bits are taken on rising `spi_sck` edges while `spi_csn` is low, most significant bit first, and eight bits make one byte.
- R2: Command 03h takes three address bytes, high byte first. It then returns array bytes from that address on `spi_miso`, most significant bit first, and the address advances by one for each byte for as long as `spi_csn` stays low.
- R3: Command 0Bh takes three address bytes and one dummy byte, and then returns array bytes in the same way as R2.
- R4: Command 06h sets the write-enable latch and command 04h clears it; each takes effect when `spi_csn` rises. Command 05h returns a status byte repeatedly. Bit 1 of the status byte is the latch, and all other bits are 0.
- R5: Commands 20h, 52h and D8h take three address bytes. Command 60h or C7h takes no address. When `spi_csn` rises on a byte boundary, the block pulses `op_valid` for one cycle with `op_kind` set as follows: 1 for 20h, 2 for 52h, 3 for D8h, 4 for a chip erase. For the three address-based commands `op_addr` is the received address; for a chip erase it is 0.
- R6: If the write-enable latch is clear, an erase or program command produces no `op_valid` and no `wr_valid`.
- R7: An accepted erase or program clears the write-enable latch.
- R8: Command 02h takes three address bytes, and each following data byte appears on `wr_valid`/`wr_addr`/`wr_data`. The low 8 address bits advance modulo 256 and the upper bits stay fixed. If at least one data byte was received, a rise of `spi_csn` on a byte boundary gives `op_valid` with `op_kind` 5 and `op_addr` set to the start address.
- R9: If `spi_csn` rises when a byte is only partly shifted in, the frame ends with no request and the latch is left unchanged.
- R10: An unknown command code (for example 3Bh, BBh, A2h or 01h) causes the rest of the frame to be ignored. `spi_miso` stays 0, no request is issued, and the latch is left unchanged.
- R11: Command 9Fh returns the ID bytes of the `ID_VALUE` parameter, most significant byte first, and repeats them in a cycle for as long as `spi_csn` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, sampled by `clk` |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| rd_req | output | 1 | Array read request |
| rd_addr | output | 24 | Array read address |
| rd_data | input | 8 | Array read data, valid the cycle after `rd_req` |
| wr_valid | output | 1 | Program data byte strobe |
| wr_addr | output | 24 | Program byte address |
| wr_data | output | 8 | Program byte value |
| op_valid | output | 1 | Committed erase/program strobe |
| op_kind | output | 3 | Operation code, see R5 and R8 |
| op_addr | output | 24 | Operation address |

## Verification
Some rules are checked by assertions on every cycle:
- no erase/program strobe or program data byte appears without the write-enable latch set;
- the latch is clear after a commit;
- commits happen only once chip select is high;
- every frame starts with an empty bit counter;
- a data-out load never collides with a shift edge.

Other behaviour can only be shown by the bench's scenarios, which compare serial output bytes and strobes against values worked out from the requirements. These cover:
- the byte counts chosen for each command code;
- read address advance;
- page wrap of the program address;
- status and ID contents;
- aborts caused by a partial byte or an unknown code.

// File: rtl/spi_flash_pkg.sv
// Package: shared types and command decoding for the flash frame decoder.
// Assumes: command codes are 8 bits; unknown codes map to ACT_NONE.
package spi_flash_pkg;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_WREN, ACT_WRDI, ACT_SECT, ACT_B32, ACT_B64,
        ACT_CHIP, ACT_PROG, ACT_READ, ACT_FREAD, ACT_STAT, ACT_ID
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DIN, ST_DOUT, ST_WAIT, ST_SKIP
    } st_e;

    typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_ID} src_e;

    localparam logic [2:0] OPK_SECT = 3'd1;
    localparam logic [2:0] OPK_B32  = 3'd2;
    localparam logic [2:0] OPK_B64  = 3'd3;
    localparam logic [2:0] OPK_CHIP = 3'd4;
    localparam logic [2:0] OPK_PROG = 3'd5;

    // Map a received command code to the action it starts.
    function automatic act_e decode_cmd(input logic [7:0] code);
        case (code)
            8'h06:        return ACT_WREN;
            8'h04:        return ACT_WRDI;
            8'h20:        return ACT_SECT;
            8'h52:        return ACT_B32;
            8'hD8:        return ACT_B64;
            8'h60, 8'hC7: return ACT_CHIP;
            8'h02:        return ACT_PROG;
            8'h03:        return ACT_READ;
            8'h0B:        return ACT_FREAD;
            8'h05:        return ACT_STAT;
            8'h9F:        return ACT_ID;
            default:      return ACT_NONE;
        endcase
    endfunction

    // Operation code reported for an erase action.
    function automatic logic [2:0] erase_kind(input act_e a);
        case (a)
            ACT_SECT: return OPK_SECT;
            ACT_B32:  return OPK_B32;
            ACT_B64:  return OPK_B64;
            default:  return OPK_CHIP;
        endcase
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
// Module: serial receive framing. Detects chip-select edges and serial clock
// rising edges, and assembles bytes MSB first.
// Assumes: serial pins are synchronous to clk and each phase lasts >= 2 clk.
module spi_frame_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_csn,
    input  logic       spi_mosi,
    output logic       sck_rise,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_done,
    output logic       at_boundary,
    output logic       frame_idle,
    output logic [7:0] rx_byte
);
    logic       sck_q;
    logic       csn_q;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;

    assign sck_rise    = spi_sck & ~sck_q & ~spi_csn;
    assign cs_fall     = ~spi_csn & csn_q;
    assign cs_rise     = spi_csn & ~csn_q;
    assign byte_done   = sck_rise & (bit_cnt == 3'd7);
    assign at_boundary = (bit_cnt == 3'd0);
    assign frame_idle  = csn_q;
    assign rx_byte     = {shreg, spi_mosi};

    // Keep one-cycle history of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= spi_sck;
            csn_q <= spi_csn;
        end
    end

    // Count bits and shift data in; cleared while chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= 3'd0;
            shreg   <= 7'd0;
        end else if (spi_csn) begin
            bit_cnt <= 3'd0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= {shreg[5:0], spi_mosi};
        end
    end

    assert_fresh_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |-> (bit_cnt == 3'd0));

endmodule

// File: rtl/spi_flash_ctrl.sv
// Module: command sequencer. Walks each frame through command, address,
// dummy and data phases, keeps the write-enable latch and issues requests.
// Assumes: byte_done, cs_rise and cs_fall come from spi_frame_rx.
module spi_flash_ctrl
    import spi_flash_pkg::*;
#(
    parameter int              ADDR_BYTES = 3,
    parameter int              PAGE_BITS  = 8,
    parameter int              ID_BYTES   = 3,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'hC2_25_17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  byte_done,
    input  logic                  at_boundary,
    input  logic                  frame_idle,
    input  logic [7:0]            rx_byte,
    output logic                  dout_active,
    output logic                  fetch,
    output logic                  fetch_mem,
    output logic [7:0]            local_byte,
    output logic [8*ADDR_BYTES-1:0] rd_addr,
    output logic                  wr_valid,
    output logic [8*ADDR_BYTES-1:0] wr_addr,
    output logic [7:0]            wr_data,
    output logic                  op_valid,
    output logic [2:0]            op_kind,
    output logic [8*ADDR_BYTES-1:0] op_addr
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int AB_W   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int IDX_W  = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    st_e               st;
    act_e              act;
    src_e              src;
    logic              wel;
    logic              got_data;
    logic [AB_W-1:0]   abyte;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] full_addr;
    logic [7:0]        id_byte;

    assign full_addr   = {addr[ADDR_W-9:0], rx_byte};
    assign dout_active = (st == ST_DOUT);
    assign fetch_mem   = (src == SRC_MEM);
    assign rd_addr     = addr;
    assign id_byte     = ID_VALUE[8*(ID_BYTES-1-int'(idx)) +: 8];
    assign local_byte  = (src == SRC_STAT) ? {6'd0, wel, 1'b0} : id_byte;

    // Phase sequencing, latch updates and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            act      <= ACT_NONE;
            src      <= SRC_MEM;
            wel      <= 1'b0;
            got_data <= 1'b0;
            abyte    <= '0;
            idx      <= '0;
            addr     <= '0;
            fetch    <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= 8'd0;
            op_valid <= 1'b0;
            op_kind  <= 3'd0;
            op_addr  <= '0;
        end else begin
            fetch    <= 1'b0;
            wr_valid <= 1'b0;
            op_valid <= 1'b0;
            if (fetch && src == SRC_MEM) addr <= addr + 1'b1;
            if (fetch && src == SRC_ID)
                idx <= (idx == IDX_W'(ID_BYTES - 1)) ? '0 : idx + 1'b1;
            if (cs_fall) begin
                st       <= ST_OPC;
                act      <= ACT_NONE;
                addr     <= '0;
                abyte    <= '0;
                idx      <= '0;
                got_data <= 1'b0;
            end else if (cs_rise) begin
                if (at_boundary && st == ST_WAIT) begin
                    case (act)
                        ACT_WREN: wel <= 1'b1;
                        ACT_WRDI: wel <= 1'b0;
                        ACT_SECT, ACT_B32, ACT_B64, ACT_CHIP: begin
                            if (wel) begin
                                op_valid <= 1'b1;
                                op_kind  <= erase_kind(act);
                                op_addr  <= addr;
                                wel      <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end else if (at_boundary && st == ST_DIN && got_data && wel) begin
                    op_valid <= 1'b1;
                    op_kind  <= OPK_PROG;
                    op_addr  <= addr;
                    wel      <= 1'b0;
                end
                st <= ST_IDLE;
            end else if (byte_done) begin
                case (st)
                    ST_OPC: begin
                        act <= decode_cmd(rx_byte);
                        case (decode_cmd(rx_byte))
                            ACT_NONE: st <= ST_SKIP;
                            ACT_WREN, ACT_WRDI, ACT_CHIP: st <= ST_WAIT;
                            ACT_STAT: begin
                                st <= ST_DOUT; src <= SRC_STAT; fetch <= 1'b1;
                            end
                            ACT_ID: begin
                                st <= ST_DOUT; src <= SRC_ID; fetch <= 1'b1;
                            end
                            default: st <= ST_ADDR;
                        endcase
                    end
                    ST_ADDR: begin
                        addr  <= full_addr;
                        abyte <= abyte + 1'b1;
                        if (abyte == AB_W'(ADDR_BYTES - 1)) begin
                            wr_addr <= full_addr;
                            case (act)
                                ACT_READ: begin
                                    st <= ST_DOUT; src <= SRC_MEM; fetch <= 1'b1;
                                end
                                ACT_FREAD: st <= ST_DUMMY;
                                ACT_PROG:  st <= ST_DIN;
                                default:   st <= ST_WAIT;
                            endcase
                        end
                    end
                    ST_DUMMY: begin
                        st <= ST_DOUT; src <= SRC_MEM; fetch <= 1'b1;
                    end
                    ST_DIN: begin
                        if (wel) begin
                            wr_valid <= 1'b1;
                            wr_data  <= rx_byte;
                            got_data <= 1'b1;
                            if (wr_valid || got_data)
                                wr_addr <= {wr_addr[ADDR_W-1:PAGE_BITS],
                                            wr_addr[PAGE_BITS-1:0] + 1'b1};
                        end
                    end
                    ST_DOUT: fetch <= 1'b1;
                    ST_WAIT: st <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assert_op_needs_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wel));
    assert_stream_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wel);
    assert_latch_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !wel);
    assert_commit_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> frame_idle);
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_valid, wr_valid, fetch}));

endmodule

// File: rtl/spi_tx_shifter.sv
// Module: serial transmit path. Loads a byte two cycles after a fetch (array
// data or a locally formed byte) and shifts it out MSB first.
// Assumes: the array returns rd_data on the cycle after the request.
module spi_tx_shifter
    import spi_flash_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_rise,
    input  logic       byte_done,
    input  logic       active,
    input  logic       fetch,
    input  logic       fetch_mem,
    input  logic [7:0] local_byte,
    input  logic [7:0] rd_data,
    output logic       spi_miso
);
    logic       pend;
    logic       pend_mem;
    logic [7:0] pend_byte;
    logic [7:0] txr;

    assign spi_miso = active & txr[7];

    // Stage the byte source, then load or shift the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_mem  <= 1'b0;
            pend_byte <= 8'd0;
            txr       <= 8'd0;
        end else begin
            pend <= fetch;
            if (fetch) begin
                pend_mem  <= fetch_mem;
                pend_byte <= local_byte;
            end
            if (pend)
                txr <= pend_mem ? rd_data : pend_byte;
            else if (sck_rise && active && !byte_done)
                txr <= {txr[6:0], 1'b0};
        end
    end

    assert_no_load_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && active) |-> !pend);

endmodule

// File: rtl/spi_flash_cmd_decoder.sv
// Module: top of the flash command frame decoder. Connects receive framing,
// command sequencing and the transmit shifter.
// Assumes: serial pins synchronous to clk, each serial phase >= 4 clk.
module spi_flash_cmd_decoder
    import spi_flash_pkg::*;
#(
    parameter int              ADDR_BYTES = 3,
    parameter int              PAGE_BITS  = 8,
    parameter int              ID_BYTES   = 3,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'hC2_25_17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_csn,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    rd_req,
    output logic [8*ADDR_BYTES-1:0] rd_addr,
    input  logic [7:0]              rd_data,
    output logic                    wr_valid,
    output logic [8*ADDR_BYTES-1:0] wr_addr,
    output logic [7:0]              wr_data,
    output logic                    op_valid,
    output logic [2:0]              op_kind,
    output logic [8*ADDR_BYTES-1:0] op_addr
);
    logic       sck_rise, cs_fall, cs_rise, byte_done, at_boundary, frame_idle;
    logic [7:0] rx_byte;
    logic       dout_active, fetch, fetch_mem;
    logic [7:0] local_byte;

    assign rd_req = fetch & fetch_mem;

    spi_frame_rx i_rx (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .sck_rise(sck_rise), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .byte_done(byte_done), .at_boundary(at_boundary),
        .frame_idle(frame_idle), .rx_byte(rx_byte)
    );

    spi_flash_ctrl #(
        .ADDR_BYTES(ADDR_BYTES), .PAGE_BITS(PAGE_BITS),
        .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .byte_done(byte_done), .at_boundary(at_boundary),
        .frame_idle(frame_idle), .rx_byte(rx_byte),
        .dout_active(dout_active), .fetch(fetch), .fetch_mem(fetch_mem),
        .local_byte(local_byte), .rd_addr(rd_addr), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr)
    );

    spi_tx_shifter i_tx (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .byte_done(byte_done),
        .active(dout_active), .fetch(fetch), .fetch_mem(fetch_mem),
        .local_byte(local_byte), .rd_data(rd_data), .spi_miso(spi_miso)
    );

endmodule

// File: tb/test_spi_flash_cmd_decoder.sv
// Bench: directed scenarios, one task each, with an array-model stub.
module test_spi_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam logic [23:0] ID = 24'hC2_25_17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, rd_req, wr_valid, op_valid;
    logic [23:0] rd_addr, wr_addr, op_addr;
    logic [7:0] rd_data = 8'd0, wr_data;
    logic [2:0] op_kind;

    int n_chk = 0, n_err = 0, cyc = 0;
    int n_op = 0, n_wr = 0;
    logic [2:0]  last_kind;
    logic [23:0] last_oaddr;
    logic [23:0] wa [0:15];
    logic [7:0]  wd [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_cmd_decoder i_spi_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr)
    );

    function automatic logic [7:0] arr(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // Array model: registered read, one cycle latency.
    always @(posedge clk) if (rd_req) rd_data <= arr(rd_addr);

    // Event monitor.
    always @(posedge clk) if (rst_n) begin
        if (op_valid) begin n_op++; last_kind = op_kind; last_oaddr = op_addr; end
        if (wr_valid) begin
            if (n_wr < 16) begin wa[n_wr] = wr_addr; wd[n_wr] = wr_data; end
            n_wr++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_err++;
            $display("FAIL all: watchdog got %0d cycles expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'd0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            clks(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            clks(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic cs_on();
        spi_csn = 1'b0;
        clks(HALF);
    endtask

    task automatic cs_off();
        clks(HALF);
        spi_csn = 1'b1;
        clks(6);
    endtask

    task automatic cmd1(input logic [7:0] c);
        logic [7:0] r;
        cs_on(); xb(c, r); cs_off();
    endtask

    task automatic cmd_addr(input logic [7:0] c, input logic [23:0] a);
        logic [7:0] r;
        cs_on(); xb(c, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); cs_off();
    endtask

    task automatic status(output logic [7:0] s);
        logic [7:0] r;
        cs_on(); xb(8'h05, r); xb(8'h00, s); cs_off();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1", "miso after reset", {31'd0, spi_miso}, 32'd0);
        chk("R1", "op_valid after reset", {31'd0, op_valid}, 32'd0);
        status(s);
        chk("R4", "status after reset", {24'd0, s}, 32'h00);
    endtask

    task automatic t_latch_status();
        logic [7:0] r, s1, s2;
        cmd1(8'h06);
        cs_on(); xb(8'h05, r); xb(8'h00, s1); xb(8'h00, s2); cs_off();
        chk("R4", "status first byte after set", {24'd0, s1}, 32'h02);
        chk("R4", "status repeat byte", {24'd0, s2}, 32'h02);
        cmd1(8'h04);
        status(s1);
        chk("R4", "status after clear", {24'd0, s1}, 32'h00);
    endtask

    task automatic t_read();
        logic [7:0] r, d;
        cs_on(); xb(8'h03, r); xb(8'h00, r); xb(8'hAB, r); xb(8'hFE, r);
        for (int k = 0; k < 3; k++) begin
            xb(8'h00, d);
            chk("R2", $sformatf("read byte %0d", k), {24'd0, d},
                {24'd0, arr(24'h00ABFE + 24'(k))});
        end
        cs_off();
    endtask

    task automatic t_fast_read();
        logic [7:0] r, d;
        cs_on(); xb(8'h0B, r); xb(8'h01, r); xb(8'h02, r); xb(8'h03, r);
        xb(8'h00, d);
        chk("R3", "miso during dummy byte", {24'd0, d}, 32'h00);
        for (int k = 0; k < 2; k++) begin
            xb(8'h00, d);
            chk("R3", $sformatf("fast read byte %0d", k), {24'd0, d},
                {24'd0, arr(24'h010203 + 24'(k))});
        end
        cs_off();
    endtask

    task automatic t_erase();
        int base;
        logic [7:0] s;
        base = n_op;
        cmd_addr(8'h20, 24'h123456);
        chk("R6", "erase without latch", n_op, base);
        cmd1(8'h06); cmd_addr(8'h20, 24'h123456);
        chk("R5", "sector erase count", n_op, base + 1);
        chk("R5", "sector erase kind", {29'd0, last_kind}, 32'd1);
        chk("R5", "sector erase addr", {8'd0, last_oaddr}, 32'h123456);
        status(s);
        chk("R7", "latch after erase", {24'd0, s}, 32'h00);
        cmd1(8'h06); cmd_addr(8'h52, 24'h0A8000);
        chk("R5", "32K erase kind", {29'd0, last_kind}, 32'd2);
        chk("R5", "32K erase addr", {8'd0, last_oaddr}, 32'h0A8000);
        cmd1(8'h06); cmd_addr(8'hD8, 24'h7F0000);
        chk("R5", "64K erase kind", {29'd0, last_kind}, 32'd3);
        cmd1(8'h06); cmd1(8'hC7);
        chk("R5", "chip erase kind", {29'd0, last_kind}, 32'd4);
        chk("R5", "chip erase addr", {8'd0, last_oaddr}, 32'h0);
        cmd1(8'h06); cmd1(8'h60);
        chk("R5", "chip erase alt count", n_op, base + 5);
    endtask

    task automatic t_program();
        int ob, wb;
        logic [7:0] r, s;
        ob = n_op; wb = n_wr;
        cs_on(); xb(8'h02, r); xb(8'h00, r); xb(8'h11, r); xb(8'h22, r);
        xb(8'hAA, r); cs_off();
        chk("R6", "program without latch: bytes", n_wr, wb);
        chk("R6", "program without latch: commit", n_op, ob);
        cmd1(8'h06);
        wb = n_wr;
        cs_on(); xb(8'h02, r); xb(8'h12, r); xb(8'h34, r); xb(8'hFE, r);
        for (int k = 0; k < 4; k++) xb(8'h50 + 8'(k), r);
        cs_off();
        chk("R8", "program byte count", n_wr, wb + 4);
        chk("R8", "byte 0 addr", {8'd0, wa[wb]}, 32'h1234FE);
        chk("R8", "byte 1 addr", {8'd0, wa[wb+1]}, 32'h1234FF);
        chk("R8", "byte 2 addr wraps", {8'd0, wa[wb+2]}, 32'h123400);
        chk("R8", "byte 3 data", {24'd0, wd[wb+3]}, 32'h53);
        chk("R8", "program commit kind", {29'd0, last_kind}, 32'd5);
        chk("R8", "program commit addr", {8'd0, last_oaddr}, 32'h1234FE);
        status(s);
        chk("R7", "latch after program", {24'd0, s}, 32'h00);
    endtask

    task automatic t_abort();
        int ob;
        logic [7:0] r, s;
        cs_on(); bits(8'h06, 5, r); cs_off();
        status(s);
        chk("R9", "partial set command", {24'd0, s}, 32'h00);
        cmd1(8'h06);
        ob = n_op;
        cs_on(); xb(8'h20, r); xb(8'h00, r); xb(8'h10, r); xb(8'h00, r);
        bits(8'hFF, 3, r); cs_off();
        chk("R9", "erase with partial trailing byte", n_op, ob);
        status(s);
        chk("R9", "latch kept after abort", {24'd0, s}, 32'h02);
        cmd1(8'h04);
    endtask

    task automatic t_unknown();
        int ob, wb;
        logic [7:0] r, orv;
        cmd1(8'h06);
        ob = n_op; wb = n_wr;
        orv = 8'd0;
        cs_on(); xb(8'h3B, r); orv |= r;
        for (int k = 0; k < 5; k++) begin xb(8'h00, r); orv |= r; end
        cs_off();
        chk("R10", "miso on unknown code", {24'd0, orv}, 32'h00);
        cs_on(); xb(8'hA2, r); xb(8'h00, r); xb(8'h00, r); xb(8'h10, r);
        xb(8'h77, r); cs_off();
        chk("R10", "no stream on unknown", n_wr, wb);
        chk("R10", "no commit on unknown", n_op, ob);
        status(r);
        chk("R10", "latch kept on unknown", {24'd0, r}, 32'h02);
        cmd1(8'h04);
    endtask

    task automatic t_jedec();
        logic [7:0] r, d;
        cs_on(); xb(8'h9F, r);
        for (int k = 0; k < 4; k++) begin
            xb(8'h00, d);
            chk("R11", $sformatf("id byte %0d", k), {24'd0, d},
                {24'd0, ID[8*(2-(k%3)) +: 8]});
        end
        cs_off();
    endtask

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(5);
        t_reset();
        t_latch_status();
        t_read();
        t_fast_read();
        t_erase();
        t_program();
        t_abort();
        t_unknown();
        t_jedec();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule